// File: doc/BRIEF.md
# Supply-Cycling Protection Supervisor

This block sequences the life of a switching power controller around its own supply rail. A set of comparator flags says where the supply sits relative to five thresholds (about 4 V, 6.5 V, 7 V, 11 V and 17 V). From these flags the supervisor decides when the power stage may switch, when the high-voltage startup path charges the supply capacitor, and when a reduced internal sink slows the discharge of that capacitor after a fault.

While switching, the supervisor watches five fault sources. Four are level conditions that must persist for a set number of clock cycles: supply overvoltage, feedback stuck high, a thermal-pin level below a slow threshold, and a thermal-pin level below a fast threshold. The fifth counts current-sense samples, one per gate strobe, that read below a short-circuit floor. A fault stops switching at once and raises the lockout level to 11 V. An auto-restart fault clears when the supply falls through 11 V, and the device then restarts through the normal charge path. A latched fault keeps the supply cycling between 7 V and 17 V without switching, until the supply collapses below 4 V. A configuration input decides which of the two classes the feedback fault belongs to.

Top module: `psv_supervisor`

## Requirements
- R1: After reset the block is charging (`hv_start_en`=1, all other outputs 0). It enters run (`run_en`=1, `hv_start_en`=0) on the first clock edge that samples `vdd_ge_start`=1.
- R2: With no fault pending, run continues while `vdd_ge_uvlo`=1 even when the supply is below 11 V. The first edge that samples `vdd_ge_uvlo`=0 stops run and returns to charging.
- R3: Any fault trip stops run on the edge where it occurs. Nothing is enabled while `vdd_ge_flt_lo`=1. The first edge that samples `vdd_ge_flt_lo`=0 turns on `sink_en`.
- R4: An auto-restart fault shows `fault_auto`=1 until the supply falls below 11 V, and then clears together with its cause bits. The sink then stays on until `vdd_ge_chg`=0, which begins charging. Run resumes at `vdd_ge_start`.
- R5: A latched fault holds `fault_latch`=1. With the sink on, `vdd_ge_chg`=0 turns on charging. `vdd_ge_start`=1 turns charging off without starting run, and the cycle repeats. Any edge that samples `vdd_ge_clear`=0 clears the latch and returns to charging.
- R6: `ovp_hi` held for OVP_CYC consecutive cycles while running trips a latched fault with cause bit 0.
- R7: `fb_hi` held for OLP_CYC consecutive cycles trips cause bit 1. It is latched when `cfg_olp_latch`=1 and auto-restart when it is 0.
- R8: `rt_warm` held for OTP_SLOW_CYC cycles trips latched cause bit 2. `rt_trip` held for OTP_FAST_CYC cycles trips latched cause bit 3.
- R9: SCP_COUNT consecutive `cs_strobe` pulses with `cs_low`=1 trip an auto-restart fault with cause bit 4. A strobe with `cs_low`=0 restarts the count.
- R10: A level debounce count restarts whenever its condition is low for one cycle before the count completes.
- R11: When latched and auto-restart trips occur on the same edge, the latched fault wins, and only the latched causes are recorded in `fault_cause`.
- R12: At most one of `run_en`, `hv_start_en` and `sink_en` is high at a time. `fault_cause` is nonzero whenever `fault_latch` or `fault_auto` is high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_olp_latch | input | 1 | 1: feedback fault latches; 0: auto-restart |
| vdd_ge_start | input | 1 | Supply at or above start level (17 V) |
| vdd_ge_flt_lo | input | 1 | Supply at or above fault lockout (11 V) |
| vdd_ge_chg | input | 1 | Supply at or above recharge level (7 V) |
| vdd_ge_uvlo | input | 1 | Supply at or above normal lockout (6.5 V) |
| vdd_ge_clear | input | 1 | Supply at or above latch clear level (4 V) |
| ovp_hi | input | 1 | Supply overvoltage comparator |
| fb_hi | input | 1 | Feedback above open-loop level |
| rt_warm | input | 1 | Thermal pin below slow threshold |
| rt_trip | input | 1 | Thermal pin below fast threshold |
| cs_strobe | input | 1 | One-cycle pulse at the current-sense sample point |
| cs_low | input | 1 | Sampled current sense below short-circuit floor |
| run_en | output | 1 | Switching allowed |
| hv_start_en | output | 1 | High-voltage startup charging on |
| sink_en | output | 1 | Reduced supply sink on |
| fault_latch | output | 1 | Latched fault active |
| fault_auto | output | 1 | Auto-restart fault active (above 11 V) |
| fault_cause | output | 5 | Bit 0 OVP, 1 feedback, 2 thermal slow, 3 thermal fast, 4 sense short |

## Verification
The bench shrinks the overvoltage, feedback and thermal windows to 4, 8, 10 and 3 cycles and keeps the sense-short count at 11. With these values every trip boundary, one cycle before and on the trip edge, can be reached in a few dozen cycles. Full latch and auto-restart supply cycles can then run back to back, along with a debounce restart and a same-edge collision between a latched and an auto-restart trip. The supply flags are driven as a monotonic level code, so the order of the thresholds is exercised as a real rail would present it.

// File: rtl/psv_pkg.sv
package psv_pkg;

  localparam int CAUSE_W   = 5;
  localparam int C_OVP     = 0;
  localparam int C_OLP     = 1;
  localparam int C_OTP_SLW = 2;
  localparam int C_OTP_FST = 3;
  localparam int C_SCP     = 4;
  localparam int LVL_N     = 4;

  typedef enum logic [2:0] {
    ST_CHARGE  = 3'd0,
    ST_RUN     = 3'd1,
    ST_A_HOLD  = 3'd2,
    ST_A_SINK  = 3'd3,
    ST_L_HOLD  = 3'd4,
    ST_L_SINK  = 3'd5,
    ST_L_CHG   = 3'd6
  } psv_state_t;

endpackage

// File: rtl/psv_dwell.sv
module psv_dwell #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cond,
  output logic trip
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LIM = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Count consecutive qualified cycles; any gap restarts the window.
  always_comb begin
    cnt_d = cnt_q;
    if (!(en && cond))   cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trip = en && cond && (cnt_q == LIM);

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  generate
    if (LEN > 1) begin : g_hist
      // R10: a trip needs the condition on the previous cycle too
      p_trip_history_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> ($past(cond) && $past(en)));
    end
  endgenerate

endmodule

// File: rtl/psv_scp_count.sv
module psv_scp_count #(
  parameter int N = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  input  logic low,
  output logic trip
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LIM = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                          cnt_d = '0;
    else if (strobe && !low)          cnt_d = '0;
    else if (strobe && cnt_q != LIM)  cnt_d = cnt_q + 1'b1;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trip = en && strobe && low && (cnt_q == LIM);

  // R9: a good sample always restarts the run of low samples
  p_good_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !low) |=> (cnt_q == '0));

  p_scp_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/psv_sequencer.sv
module psv_sequencer
  import psv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vdd_ge_start,
  input  logic               vdd_ge_flt_lo,
  input  logic               vdd_ge_chg,
  input  logic               vdd_ge_uvlo,
  input  logic               vdd_ge_clear,
  input  logic [CAUSE_W-1:0] latch_set,
  input  logic [CAUSE_W-1:0] auto_set,
  output logic               run_en,
  output logic               hv_start_en,
  output logic               sink_en,
  output logic               fault_latch,
  output logic               fault_auto,
  output logic [CAUSE_W-1:0] fault_cause
);
  psv_state_t         st_q, st_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               st_en, cause_en;
  logic               latch_trip, auto_trip;

  assign latch_trip = |latch_set;
  assign auto_trip  = |auto_set;

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    unique case (st_q)
      ST_CHARGE: if (vdd_ge_start) st_d = ST_RUN;
      ST_RUN: begin
        if (latch_trip) begin
          st_d    = ST_L_HOLD;
          cause_d = latch_set;
        end else if (auto_trip) begin
          st_d    = ST_A_HOLD;
          cause_d = auto_set;
        end else if (!vdd_ge_uvlo) begin
          st_d = ST_CHARGE;
        end
      end
      ST_A_HOLD: if (!vdd_ge_flt_lo) begin
        st_d    = ST_A_SINK;
        cause_d = '0;
      end
      ST_A_SINK: if (!vdd_ge_chg) st_d = ST_CHARGE;
      ST_L_HOLD, ST_L_SINK, ST_L_CHG: begin
        if (!vdd_ge_clear) begin
          st_d    = ST_CHARGE;
          cause_d = '0;
        end else if (st_q == ST_L_HOLD && !vdd_ge_flt_lo) begin
          st_d = ST_L_SINK;
        end else if (st_q == ST_L_SINK && !vdd_ge_chg) begin
          st_d = ST_L_CHG;
        end else if (st_q == ST_L_CHG && vdd_ge_start) begin
          st_d = ST_L_HOLD;
        end
      end
      default: begin
        st_d    = ST_CHARGE;
        cause_d = '0;
      end
    endcase
    st_en    = (st_d != st_q);
    cause_en = (cause_d != cause_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_CHARGE;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign run_en      = (st_q == ST_RUN);
  assign hv_start_en = (st_q == ST_CHARGE) || (st_q == ST_L_CHG);
  assign sink_en     = (st_q == ST_A_SINK) || (st_q == ST_L_SINK);
  assign fault_auto  = (st_q == ST_A_HOLD);
  assign fault_latch = (st_q == ST_L_HOLD) || (st_q == ST_L_SINK) || (st_q == ST_L_CHG);
  assign fault_cause = cause_q;

  p_excl_outputs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_en, hv_start_en, sink_en}));

  p_cause_tracks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latch || fault_auto) == (fault_cause != '0));

  p_start_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(vdd_ge_start));

  p_uvlo_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !vdd_ge_uvlo && !latch_trip && !auto_trip) |=> hv_start_en);

  p_fault_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (latch_trip || auto_trip)) |=> !run_en);

  p_sink_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sink_en) |-> !$past(vdd_ge_flt_lo));

  p_latch_no_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latch |=> !run_en);

  p_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && latch_trip) |=> (fault_latch && !fault_auto));

endmodule

// File: rtl/psv_supervisor.sv
module psv_supervisor
  import psv_pkg::*;
#(
  parameter int OVP_CYC      = 20500,
  parameter int OLP_CYC      = 5750000,
  parameter int OTP_SLOW_CYC = 1450000,
  parameter int OTP_FAST_CYC = 18500,
  parameter int SCP_COUNT    = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_olp_latch,
  input  logic               vdd_ge_start,
  input  logic               vdd_ge_flt_lo,
  input  logic               vdd_ge_chg,
  input  logic               vdd_ge_uvlo,
  input  logic               vdd_ge_clear,
  input  logic               ovp_hi,
  input  logic               fb_hi,
  input  logic               rt_warm,
  input  logic               rt_trip,
  input  logic               cs_strobe,
  input  logic               cs_low,
  output logic               run_en,
  output logic               hv_start_en,
  output logic               sink_en,
  output logic               fault_latch,
  output logic               fault_auto,
  output logic [CAUSE_W-1:0] fault_cause
);
  logic [LVL_N-1:0]   lvl_cond;
  logic [LVL_N-1:0]   lvl_trip;
  logic               scp_trip;
  logic [CAUSE_W-1:0] latch_set, auto_set;

  // Level sources ordered to match their cause bit positions.
  assign lvl_cond[C_OVP]     = ovp_hi;
  assign lvl_cond[C_OLP]     = fb_hi;
  assign lvl_cond[C_OTP_SLW] = rt_warm;
  assign lvl_cond[C_OTP_FST] = rt_trip;

  generate
    for (genvar i = 0; i < LVL_N; i++) begin : g_lvl
      localparam int WIN = (i == C_OVP) ? OVP_CYC :
                           (i == C_OLP) ? OLP_CYC :
                           (i == C_OTP_SLW) ? OTP_SLOW_CYC : OTP_FAST_CYC;
      psv_dwell #(.LEN(WIN)) u_dwell (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (run_en),
        .cond (lvl_cond[i]),
        .trip (lvl_trip[i])
      );
    end
  endgenerate

  psv_scp_count #(.N(SCP_COUNT)) u_scp (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_en),
    .strobe(cs_strobe),
    .low   (cs_low),
    .trip  (scp_trip)
  );

  always_comb begin
    latch_set            = '0;
    auto_set             = '0;
    latch_set[C_OVP]     = lvl_trip[C_OVP];
    latch_set[C_OTP_SLW] = lvl_trip[C_OTP_SLW];
    latch_set[C_OTP_FST] = lvl_trip[C_OTP_FST];
    latch_set[C_OLP]     = lvl_trip[C_OLP] && cfg_olp_latch;
    auto_set[C_OLP]      = lvl_trip[C_OLP] && !cfg_olp_latch;
    auto_set[C_SCP]      = scp_trip;
  end

  psv_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .vdd_ge_start (vdd_ge_start),
    .vdd_ge_flt_lo(vdd_ge_flt_lo),
    .vdd_ge_chg   (vdd_ge_chg),
    .vdd_ge_uvlo  (vdd_ge_uvlo),
    .vdd_ge_clear (vdd_ge_clear),
    .latch_set    (latch_set),
    .auto_set     (auto_set),
    .run_en       (run_en),
    .hv_start_en  (hv_start_en),
    .sink_en      (sink_en),
    .fault_latch  (fault_latch),
    .fault_auto   (fault_auto),
    .fault_cause  (fault_cause)
  );

  // R7: the configuration input decides the class of the feedback fault
  p_olp_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && lvl_trip[C_OLP] && !cfg_olp_latch && !(|latch_set)) |=> fault_auto);

endmodule

// File: tb/sim_psv_supervisor.sv
module sim_psv_supervisor;

  typedef struct {
    bit       run;
    bit       hv;
    bit       sink;
    bit       fl;
    bit       fa;
    bit [4:0] cause;
    string    tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_olp_latch = 1'b0;
  logic vdd_ge_start = 1'b0, vdd_ge_flt_lo = 1'b0, vdd_ge_chg = 1'b0;
  logic vdd_ge_uvlo = 1'b0, vdd_ge_clear = 1'b0;
  logic ovp_hi = 1'b0, fb_hi = 1'b0, rt_warm = 1'b0, rt_trip = 1'b0;
  logic cs_strobe = 1'b0, cs_low = 1'b0;
  logic run_en, hv_start_en, sink_en, fault_latch, fault_auto;
  logic [4:0] fault_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  psv_supervisor #(
    .OVP_CYC(4), .OLP_CYC(8), .OTP_SLOW_CYC(10), .OTP_FAST_CYC(3), .SCP_COUNT(11)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_olp_latch(cfg_olp_latch),
    .vdd_ge_start(vdd_ge_start), .vdd_ge_flt_lo(vdd_ge_flt_lo),
    .vdd_ge_chg(vdd_ge_chg), .vdd_ge_uvlo(vdd_ge_uvlo), .vdd_ge_clear(vdd_ge_clear),
    .ovp_hi(ovp_hi), .fb_hi(fb_hi), .rt_warm(rt_warm), .rt_trip(rt_trip),
    .cs_strobe(cs_strobe), .cs_low(cs_low),
    .run_en(run_en), .hv_start_en(hv_start_en), .sink_en(sink_en),
    .fault_latch(fault_latch), .fault_auto(fault_auto), .fault_cause(fault_cause)
  );

  // Supply level code: 0 <4V, 1 4..6.5, 2 6.5..7, 3 7..11, 4 11..17, 5 >=17
  task automatic set_vdd(input int lvl);
    vdd_ge_clear  = (lvl >= 1);
    vdd_ge_uvlo   = (lvl >= 2);
    vdd_ge_chg    = (lvl >= 3);
    vdd_ge_flt_lo = (lvl >= 4);
    vdd_ge_start  = (lvl >= 5);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input bit run, input bit hv, input bit sink,
                            input bit fl, input bit fa, input bit [4:0] cause,
                            input string tag);
    exp_t e;
    e.run = run; e.hv = hv; e.sink = sink; e.fl = fl; e.fa = fa;
    e.cause = cause; e.tag = tag;
    q.push_back(e);
    #1;
  endtask

  task automatic sense_pulse(input bit low);
    cs_strobe = 1'b1;
    cs_low    = low;
    step(1);
    cs_strobe = 1'b0;
    cs_low    = 1'b0;
    step(1);
  endtask

  // Monitor: pops expected items and compares with the live outputs.
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (run_en !== e.run || hv_start_en !== e.hv || sink_en !== e.sink ||
            fault_latch !== e.fl || fault_auto !== e.fa || fault_cause !== e.cause) begin
          errors++;
          $display("FAIL %s: got run=%b hv=%b sink=%b fl=%b fa=%b cause=%b, want run=%b hv=%b sink=%b fl=%b fa=%b cause=%b",
                   e.tag, run_en, hv_start_en, sink_en, fault_latch, fault_auto, fault_cause,
                   e.run, e.hv, e.sink, e.fl, e.fa, e.cause);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_vdd(0);
    step(2);
    rst_n = 1'b1;
    step(1);
    expect_out(0, 1, 0, 0, 0, 5'b00000, "R1 reset charging");
    set_vdd(4);
    step(2);
    expect_out(0, 1, 0, 0, 0, 5'b00000, "R1 no start below 17V");
    set_vdd(5);
    step(1);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R1 start at 17V");

    set_vdd(3);
    step(2);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R2 runs below 11V without fault");
    set_vdd(1);
    step(1);
    expect_out(0, 1, 0, 0, 0, 5'b00000, "R2 stop at uvlo");
    set_vdd(5);
    step(1);

    // Overvoltage: latched fault and full latch cycle
    ovp_hi = 1'b1;
    step(3);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R6 ovp one cycle short");
    step(1);
    expect_out(0, 0, 0, 1, 0, 5'b00001, "R6 ovp trip latched");
    ovp_hi = 1'b0;
    set_vdd(4);
    step(2);
    expect_out(0, 0, 0, 1, 0, 5'b00001, "R3 nothing enabled above 11V");
    set_vdd(3);
    step(1);
    expect_out(0, 0, 1, 1, 0, 5'b00001, "R3 sink below 11V");
    set_vdd(2);
    step(1);
    expect_out(0, 1, 0, 1, 0, 5'b00001, "R5 latch recharge below 7V");
    set_vdd(5);
    step(1);
    expect_out(0, 0, 0, 1, 0, 5'b00001, "R5 no run at 17V while latched");
    set_vdd(3);
    step(1);
    expect_out(0, 0, 1, 1, 0, 5'b00001, "R5 latch sink again");
    set_vdd(0);
    step(1);
    expect_out(0, 1, 0, 0, 0, 5'b00000, "R5 latch clears below 4V");

    // Feedback fault as auto-restart
    set_vdd(5);
    step(1);
    fb_hi = 1'b1;
    step(7);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R7 olp one cycle short");
    step(1);
    expect_out(0, 0, 0, 0, 1, 5'b00010, "R7 olp auto trip");
    fb_hi = 1'b0;
    set_vdd(3);
    step(1);
    expect_out(0, 0, 1, 0, 0, 5'b00000, "R4 auto clears at 11V with sink");
    set_vdd(2);
    step(1);
    expect_out(0, 1, 0, 0, 0, 5'b00000, "R4 auto recharge below 7V");
    set_vdd(5);
    step(1);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R4 auto resumes at 17V");

    // Feedback fault as latched
    cfg_olp_latch = 1'b1;
    fb_hi = 1'b1;
    step(8);
    expect_out(0, 0, 0, 1, 0, 5'b00010, "R7 olp latched variant");
    fb_hi = 1'b0;
    cfg_olp_latch = 1'b0;
    set_vdd(0);
    step(1);
    set_vdd(5);
    step(1);

    // Debounce restart then fast thermal trip
    rt_trip = 1'b1;
    step(2);
    rt_trip = 1'b0;
    step(1);
    rt_trip = 1'b1;
    step(2);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R10 window restarted after gap");
    step(1);
    expect_out(0, 0, 0, 1, 0, 5'b01000, "R8 fast thermal trip");
    rt_trip = 1'b0;
    set_vdd(0);
    step(1);
    set_vdd(5);
    step(1);

    rt_warm = 1'b1;
    step(9);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R8 slow thermal one short");
    step(1);
    expect_out(0, 0, 0, 1, 0, 5'b00100, "R8 slow thermal trip");
    rt_warm = 1'b0;
    set_vdd(0);
    step(1);
    set_vdd(5);
    step(1);

    // Sense short with a good sample in the middle
    for (int i = 0; i < 10; i++) sense_pulse(1'b1);
    sense_pulse(1'b0);
    for (int i = 0; i < 10; i++) sense_pulse(1'b1);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R9 count restarted by good sample");
    cs_strobe = 1'b1;
    cs_low = 1'b1;
    step(1);
    cs_strobe = 1'b0;
    cs_low = 1'b0;
    expect_out(0, 0, 0, 0, 1, 5'b10000, "R9 eleventh low sample trips");
    set_vdd(3);
    step(1);
    expect_out(0, 0, 1, 0, 0, 5'b00000, "R4 scp clears at 11V");
    set_vdd(2);
    step(1);
    set_vdd(5);
    step(1);
    expect_out(1, 0, 0, 0, 0, 5'b00000, "R4 scp restart");

    // Same-edge collision: latched overvoltage and auto sense short
    for (int i = 0; i < 10; i++) sense_pulse(1'b1);
    ovp_hi = 1'b1;
    step(3);
    cs_strobe = 1'b1;
    cs_low = 1'b1;
    step(1);
    cs_strobe = 1'b0;
    cs_low = 1'b0;
    ovp_hi = 1'b0;
    expect_out(0, 0, 0, 1, 0, 5'b00001, "R11 latch wins same-edge");
    set_vdd(0);
    step(1);
    expect_out(0, 1, 0, 0, 0, 5'b00000, "R12 cause cleared with latch");

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule